// File: doc/BRIEF.md
# Mask-Driven Vector Lane Compressor

This block moves the lanes of an N-lane vector of W-bit elements under the control of an N-bit lane-select mask. In compress mode the selected lanes are packed toward lane 0 and keep their relative order. In expand mode it does the reverse: consecutive low input lanes are spread out to the selected output positions. A fill option chooses what lands in the output lanes that no selected lane claims. With zero fill they read zero. With sheep-and-goats fill the unselected lanes are packed above the selected ones, again in their original order, so the lane movement becomes a complete permutation. An index base can be added to every destination, and the block reports how many lanes the mask selects.

Each lane's destination comes from an exclusive prefix count of the mask. That count is built as a logarithmic-depth parallel scan, and the last lane of the inclusive scan gives the population count. A second scan over the inverted mask, offset by the population count, places the unselected lanes. Compress then scatters each enabled input lane to its destination. Expand gathers each enabled output lane from the input lane the same map names. The result is registered, so it appears one cycle after the request together with a valid strobe.

Top module: `lane_packer`

## Requirements
- R1: In compress mode (in_op = 0), selected input lane i goes to output lane in_base + (number of selected lanes below i). The lowest selected lane therefore lands at in_base, and the selected lanes keep their relative order.
- R2: out_count equals the number of 1 bits in the in_mask of the accepted request. It does not depend on in_base or on the modes.
- R3: With zero fill (in_sag = 0), every output lane that no selected lane reaches reads zero. In compress mode these are the lanes below in_base and the lanes at or above in_base + out_count.
- R4: In compress mode with sheep-and-goats fill (in_sag = 1), unselected input lane i goes to output lane in_base + out_count + (number of unselected lanes below i). With mask 0b00001001 and in_base 0, the output lanes 7..0 hold input lanes 7,6,5,4,2,1,3,0.
- R5: In expand mode (in_op = 1), output lane j with mask bit j set receives input lane in_base + (number of selected lanes below j), or zero if that index is N or more. With zero fill, output lanes whose mask bit is clear read zero.
- R6: In expand mode with sheep-and-goats fill, output lane j with mask bit j clear receives input lane in_base + popcount + (number of unselected lanes below j), or zero if that index is N or more.
- R7: in_base is added to every destination index. In compress mode, a lane whose destination is N or more is dropped.
- R8: A request is accepted on a rising edge where in_valid = 1. Its result and count appear at the outputs with out_valid = 1 after exactly that one edge. When in_valid = 0, out_valid is 0 on the next cycle and out_data and out_count hold their values.
- R9: While rst is high, out_valid, out_data and out_count are all zero on the following cycle.
- R10: An all-zero mask gives out_count 0. With zero fill the output is all zero. In sheep-and-goats compress mode with in_base 0, the output equals the input.
- R11: An all-ones mask in compress mode with in_base 0 returns the input unchanged, with out_count N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| in_op | input | 1 | 0 = compress, 1 = expand |
| in_sag | input | 1 | 0 = zero fill, 1 = sheep-and-goats fill |
| in_base | input | clog2(N) | Offset added to every destination index |
| in_mask | input | N | Lane-select mask, bit i selects lane i |
| in_data | input | N*W | Input vector, lane i in bits [i*W +: W] |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| out_data | output | N*W | Output vector, lane j in bits [j*W +: W] |
| out_count | output | clog2(N+1) | Number of selected lanes |

## Verification
The bench targets the lane that must land exactly at the popcount boundary. A prefix count that was inclusive instead of exclusive would shift every selected lane up by one, and a sheep-and-goats offset missing the popcount would make the unselected lanes collide with the selected ones. It exercises in_base values that push destinations past lane N-1. A design that wrapped the index instead of dropping it would write stale lanes into low positions. The all-zero and all-ones masks check the two ends of the population count, where a narrow count register would wrap to zero. Hold cycles with in_valid low catch a register that updates on every edge.

// File: rtl/lp_pkg.sv
package lp_pkg;

    // Direction of lane movement
    typedef enum logic {
        OP_COMPRESS = 1'b0,
        OP_EXPAND   = 1'b1
    } op_e;

    // What fills output lanes not claimed by a selected lane
    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_SAG  = 1'b1
    } fill_e;

    typedef struct packed {
        op_e   op;
        fill_e fill;
    } mode_t;

    // Width of a lane index
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width able to hold a count from 0 to n
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Width of a destination: base + popcount + unselected prefix stays below 4n
    function automatic int dst_width(input int n);
        return cnt_width(n) + 2;
    endfunction

endpackage

// File: rtl/lp_prefix_scan.sv
module lp_prefix_scan #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]    bits_in,
    output logic [N*CW-1:0] excl_out,
    output logic [CW-1:0]   total_out
);
    localparam int LV = (N > 1) ? $clog2(N) : 1;

    // stage[l][i]: sum of bits (i-2^l, i], a Kogge-Stone style inclusive scan
    logic [CW-1:0] stage [LV+1][N];

    genvar gi, gl;
    generate
        for (gi = 0; gi < N; gi++) begin : g_seed
            assign stage[0][gi] = CW'(bits_in[gi]);
        end
        for (gl = 0; gl < LV; gl++) begin : g_level
            localparam int STRIDE = 1 << gl;
            for (gi = 0; gi < N; gi++) begin : g_lane
                if (gi >= STRIDE) begin : g_add
                    assign stage[gl+1][gi] = stage[gl][gi] + stage[gl][gi-STRIDE];
                end else begin : g_pass
                    assign stage[gl+1][gi] = stage[gl][gi];
                end
            end
        end
        for (gi = 0; gi < N; gi++) begin : g_excl
            // exclusive count: drop this lane's own bit from the inclusive sum
            assign excl_out[gi*CW +: CW] = stage[LV][gi] - CW'(bits_in[gi]);
        end
    endgenerate

    // carry-out of the scan is the population count
    assign total_out = stage[LV][N-1];

endmodule

// File: rtl/lp_dest_map.sv
module lp_dest_map
    import lp_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3,
    parameter int CW = 4,
    parameter int DW = 6
) (
    input  logic [N-1:0]    mask,
    input  fill_e           fill,
    input  logic [IW-1:0]   base,
    input  logic [N*CW-1:0] sel_pfx,
    input  logic [N*CW-1:0] uns_pfx,
    input  logic [CW-1:0]   pop,
    output logic [N*DW-1:0] dst,
    output logic [N-1:0]    en
);
    logic [DW-1:0] goat_base;

    assign goat_base = DW'(base) + DW'(pop);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_lane
            always_comb begin
                if (mask[gi]) begin
                    dst[gi*DW +: DW] = DW'(base) + DW'(sel_pfx[gi*CW +: CW]);
                end else begin
                    dst[gi*DW +: DW] = goat_base + DW'(uns_pfx[gi*CW +: CW]);
                end
                en[gi] = mask[gi] | (fill == FILL_SAG);
            end
        end
    endgenerate

endmodule

// File: rtl/lp_lane_router.sv
module lp_lane_router
    import lp_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = 3,
    parameter int DW = 6
) (
    input  op_e             op,
    input  logic [N*W-1:0]  data_in,
    input  logic [N*DW-1:0] dst,
    input  logic [N-1:0]    en,
    output logic [N*W-1:0]  data_out
);
    logic [N*W-1:0] scatter_q;
    logic [N*W-1:0] gather_q;

    genvar gj;
    generate
        for (gj = 0; gj < N; gj++) begin : g_out
            // compress: OR together the enabled inputs aimed at this lane
            always_comb begin
                scatter_q[gj*W +: W] = '0;
                for (int i = 0; i < N; i++) begin
                    if (en[i] && (dst[i*DW +: DW] == DW'(gj))) begin
                        scatter_q[gj*W +: W] = scatter_q[gj*W +: W] | data_in[i*W +: W];
                    end
                end
            end
            // expand: this lane fetches the input lane its destination names
            always_comb begin
                gather_q[gj*W +: W] = '0;
                if (en[gj] && (dst[gj*DW +: DW] < DW'(N))) begin
                    for (int i = 0; i < N; i++) begin
                        if (dst[gj*DW +: DW] == DW'(i)) begin
                            gather_q[gj*W +: W] = data_in[i*W +: W];
                        end
                    end
                end
            end
        end
    endgenerate

    assign data_out = (op == OP_EXPAND) ? gather_q : scatter_q;

endmodule

// File: rtl/lane_packer.sv
module lane_packer
    import lp_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_op,
    input  logic                          in_sag,
    input  logic [lp_pkg::idx_width(N)-1:0] in_base,
    input  logic [N-1:0]                  in_mask,
    input  logic [N*W-1:0]                in_data,
    output logic                          out_valid,
    output logic [N*W-1:0]                out_data,
    output logic [lp_pkg::cnt_width(N)-1:0] out_count
);
    localparam int IW = idx_width(N);
    localparam int CW = cnt_width(N);
    localparam int DW = dst_width(N);

    mode_t           mode;
    logic [N*CW-1:0] sel_pfx;
    logic [N*CW-1:0] uns_pfx;
    logic [CW-1:0]   sel_tot;
    logic [CW-1:0]   uns_tot;
    logic [N*DW-1:0] dst;
    logic [N-1:0]    en;
    logic [N*W-1:0]  routed;

    assign mode.op   = op_e'(in_op);
    assign mode.fill = fill_e'(in_sag);

    lp_prefix_scan #(.N(N), .CW(CW)) u_sel_scan (
        .bits_in   (in_mask),
        .excl_out  (sel_pfx),
        .total_out (sel_tot)
    );

    lp_prefix_scan #(.N(N), .CW(CW)) u_uns_scan (
        .bits_in   (~in_mask),
        .excl_out  (uns_pfx),
        .total_out (uns_tot)
    );

    lp_dest_map #(.N(N), .IW(IW), .CW(CW), .DW(DW)) u_map (
        .mask    (in_mask),
        .fill    (mode.fill),
        .base    (in_base),
        .sel_pfx (sel_pfx),
        .uns_pfx (uns_pfx),
        .pop     (sel_tot),
        .dst     (dst),
        .en      (en)
    );

    lp_lane_router #(.N(N), .W(W), .IW(IW), .DW(DW)) u_route (
        .op       (mode.op),
        .data_in  (in_data),
        .dst      (dst),
        .en       (en),
        .data_out (routed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_count <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= routed;
                out_count <= sel_tot;
            end
        end
    end

    // Helper: every lane at index lim or above is zero
    function automatic logic lanes_zero_from(input logic [N*W-1:0] d, input int lim);
        for (int j = 0; j < N; j++) begin
            if (j >= lim && d[j*W +: W] != '0) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Helper: every lane whose mask bit is clear is zero
    function automatic logic lanes_zero_unsel(input logic [N*W-1:0] d, input logic [N-1:0] m);
        for (int j = 0; j < N; j++) begin
            if (!m[j] && d[j*W +: W] != '0) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R2
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_count == CW'($countones($past(in_mask))));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(out_data) && $stable(out_count));

    // R3
    pack_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && !in_sag) |=>
            lanes_zero_from(out_data, int'($past(in_base)) + int'(out_count)));

    // R5
    spread_gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op && !in_sag) |=> lanes_zero_unsel(out_data, $past(in_mask)));

    // R11
    full_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && (in_base == '0) && (&in_mask)) |=>
            out_data == $past(in_data));

endmodule

// File: tb/sim_lane_packer.sv
module sim_lane_packer;
    localparam int N      = 8;
    localparam int W      = 8;
    localparam int IW     = 3;
    localparam int CW     = 4;
    localparam int PERIOD = 10;
    localparam int NT     = 13;

    // table entry: {mask[7:0], op, sag, base[2:0], count[3:0]}
    localparam logic [16:0] TBL [NT] = '{
        {8'h09, 1'b0, 1'b0, 3'd0, 4'd2},
        {8'h09, 1'b0, 1'b1, 3'd0, 4'd2},
        {8'hFF, 1'b0, 1'b0, 3'd0, 4'd8},
        {8'h00, 1'b0, 1'b0, 3'd0, 4'd0},
        {8'h00, 1'b0, 1'b1, 3'd0, 4'd0},
        {8'h5A, 1'b1, 1'b0, 3'd0, 4'd4},
        {8'h5A, 1'b1, 1'b1, 3'd0, 4'd4},
        {8'hF3, 1'b0, 1'b0, 3'd3, 4'd6},
        {8'h81, 1'b0, 1'b1, 3'd2, 4'd2},
        {8'hFF, 1'b1, 1'b0, 3'd5, 4'd8},
        {8'h36, 1'b1, 1'b1, 3'd1, 4'd4},
        {8'h80, 1'b0, 1'b0, 3'd0, 4'd1},
        {8'h01, 1'b1, 1'b0, 3'd0, 4'd1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_op;
    logic          in_sag;
    logic [IW-1:0] in_base;
    logic [N-1:0]  in_mask;
    logic [N*W-1:0] in_data;
    logic          out_valid;
    logic [N*W-1:0] out_data;
    logic [CW-1:0] out_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    lane_packer #(.N(N), .W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_sag(in_sag),
        .in_base(in_base), .in_mask(in_mask), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_count(out_count)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Serial reference written from the requirements
    function automatic logic [N*W-1:0] model(input logic [N*W-1:0] d, input logic [N-1:0] m,
                                             input logic op, input logic sag, input int base);
        logic [N*W-1:0] r = '0;
        int pop = 0;
        int k;
        for (int i = 0; i < N; i++) if (m[i]) pop++;
        if (!op) begin
            k = base;
            for (int i = 0; i < N; i++) if (m[i]) begin
                if (k < N) r[k*W +: W] = d[i*W +: W];
                k++;
            end
            if (sag) begin
                k = base + pop;
                for (int i = 0; i < N; i++) if (!m[i]) begin
                    if (k < N) r[k*W +: W] = d[i*W +: W];
                    k++;
                end
            end
        end else begin
            k = base;
            for (int j = 0; j < N; j++) if (m[j]) begin
                r[j*W +: W] = (k < N) ? d[k*W +: W] : '0;
                k++;
            end
            if (sag) begin
                k = base + pop;
                for (int j = 0; j < N; j++) if (!m[j]) begin
                    r[j*W +: W] = (k < N) ? d[k*W +: W] : '0;
                    k++;
                end
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [16:0] e);
        if (e[8:6] != 3'd0)            return "R7";
        if (e[10] && e[9])             return "R6";
        if (e[10])                     return "R5";
        if (e[16:11] == 0 && e[9])     return "R10";
        if (e[16:9] == 8'h00)          return "R10";
        if (e[16:9] == 8'hFF)          return "R11";
        if (e[9])                      return "R4";
        return "R1";
    endfunction

    // Drive one request at a falling edge; on return its result is visible
    task automatic apply(input logic [N*W-1:0] d, input logic [N-1:0] m,
                         input logic op, input logic sag, input logic [IW-1:0] b);
        @(negedge clk);
        in_data  = d;
        in_mask  = m;
        in_op    = op;
        in_sag   = sag;
        in_base  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] d;
        logic [N*W-1:0] held;
        rst = 1'b1; in_valid = 1'b0; in_op = 1'b0; in_sag = 1'b0;
        in_base = '0; in_mask = '0; in_data = '0;
        repeat (3) @(negedge clk);

        // R9: reset state
        check("R9 valid", 64'(out_valid), 64'd0);
        check("R9 data", 64'(out_data), 64'd0);
        check("R9 count", 64'(out_count), 64'd0);
        rst = 1'b0;

        // Table walk
        for (int t = 0; t < NT; t++) begin
            logic [16:0] e;
            e = TBL[t];
            for (int i = 0; i < N; i++) d[i*W +: W] = 8'(8'h11 * (t + 1) + i);
            apply(d, e[16:9], e[8], e[7], e[6:4]);
            check(tag_of(e), 64'(out_data), 64'(model(d, e[16:9], e[8], e[7], int'(e[6:4]))));
            check("R2 count", 64'(out_count), 64'(e[3:0]));
        end

        // Directed: lanes 7..0 = 0x87..0x80
        for (int i = 0; i < N; i++) d[i*W +: W] = 8'(8'h80 + i);

        // R1 / R3: mask 0b00001001 packs lanes 3,0 into lanes 1,0; rest zero
        apply(d, 8'h09, 1'b0, 1'b0, 3'd0);
        check("R1 R3 pack", 64'(out_data), 64'h0000_0000_0000_8380);

        // R4: unselected lanes follow above the popcount
        apply(d, 8'h09, 1'b0, 1'b1, 3'd0);
        check("R4 sag map", 64'(out_data), 64'h8786_8584_8281_8380);

        // R10: empty mask in sag compress returns the input
        apply(d, 8'h00, 1'b0, 1'b1, 3'd0);
        check("R10 identity", 64'(out_data), 64'(d));

        // R7: base 6 with three selected lanes drops the third
        apply(d, 8'h07, 1'b0, 1'b0, 3'd6);
        check("R7 drop", 64'(out_data), 64'h8180_0000_0000_0000);

        // R8: valid timing and hold while idle
        @(negedge clk);
        held = out_data;
        check("R8 idle valid", 64'(out_valid), 64'd0);
        in_mask = 8'hFF; in_data = '1; in_op = 1'b1;
        @(negedge clk);
        check("R8 hold data", 64'(out_data), 64'(held));
        check("R8 hold count", 64'(out_count), 64'd3);
        in_valid = 1'b1; in_op = 1'b0; in_base = '0;
        @(negedge clk);
        check("R8 latency valid", 64'(out_valid), 64'd1);
        check("R11 all-ones", 64'(out_data), 64'(in_data));
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule